// File: doc/BRIEF.md
# Interleaved Two-Bank Memory Composer

This block assembles one small memory out of identical register-array sub-banks, the way a board-level memory is built from several chips. A compile-time mode decides how the CPU address is divided between the banks. The address can be split by its top bit, by its bottom bit, or by one top bit and one bottom bit together. In the last case four banks of half depth are used. A fourth mode places two banks side by side so that each word becomes twice as wide.

The CPU side is a plain synchronous bus with an address, write data, read data, and chip-select, read and write strobes. The block works out each bank's chip enable from the address and chip-select. The read strobe acts as every bank's output enable. A bank puts data forward only when both of its enables are active. The words from the banks are combined into one word and registered, so read data appears one clock after the read cycle.

Top module: `mem_composer`

## Requirements
- R1: In top-bit mode (MODE = MC_HIGH) the highest address bit selects the bank: 0 selects bank 0 (words 0 to 7) and 1 selects bank 1 (words 8 to 15). The lower three bits, in their original order, index the word inside the bank. All 16 words store independently.
- R2: In bottom-bit mode (MC_LOW) address bit 0 selects the bank (0 selects bank 0, 1 selects bank 1). Address bits 3 to 1 index the word inside the bank. All 16 words store independently.
- R3: In split mode (MC_SPLIT) the two-bit value {addr[3], addr[0]} selects one of four banks. Bits {addr[2], addr[1]} index the word inside the bank. All 16 words store independently.
- R4: In width mode (MC_WIDE) both banks receive the same address bits 2 to 0 and the same strobes, and the word is 4 bits wide. Bank 1 holds bits 3:2 and bank 0 holds bits 1:0. Addresses with bit 3 set enable no bank: a read there returns 0 and a write there changes nothing.
- R5: A read cycle (cs=1, rd=1, wr=0) puts the addressed word on rdata at the next rising clock edge.
- R6: rdata keeps its value in every cycle that is not a read cycle.
- R7: With cs=0, no bank is enabled, nothing is written and rdata holds.
- R8: When rd and wr are both high with cs=1, the write is performed and rdata keeps its previous value.
- R9: While rst_n is low, rdata is 0 and every stored word is cleared to 0.
- R10: In the three interleaved modes, at most one bank is enabled in any cycle, so a write touches exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| cs | input | 1 | Chip select for the whole memory |
| rd | input | 1 | Read strobe, also every bank's output enable |
| wr | input | 1 | Write strobe |
| wdata | input | WORD_W | Write data (2 bits, or 4 bits in width mode) |
| rdata | output | WORD_W | Registered read data |

## Verification
The bench writes every address with several patterns and then walks a single changed word across all 16 locations in all four modes. If an address bit were dropped or swapped in the bank select or the in-bank index, two addresses would alias, and a stale or overwritten word would read back. In width mode it writes to the upper half of the address space. A design that ignored bit 3 there would overwrite words 0 to 7, or would return non-zero data on those reads. It also drives write with chip-select low and read together with write. A design that wrote without chip-select, or that updated rdata during a collision, would show a changed word or a changed rdata value.

// File: rtl/mc_pkg.sv
// Shared mode type and derived-size helpers for the memory composer.
// Assumes address widths of at least 3 bits so every mode has an in-bank index.
package mc_pkg;

    typedef enum logic [1:0] {
        MC_HIGH  = 2'd0,
        MC_LOW   = 2'd1,
        MC_SPLIT = 2'd2,
        MC_WIDE  = 2'd3
    } mc_mode_e;

    // Number of sub-banks used by a mode.
    function automatic int mc_banks(mc_mode_e m);
        return (m == MC_SPLIT) ? 4 : 2;
    endfunction

    // Word width seen on the CPU side.
    function automatic int mc_word_w(mc_mode_e m, int bank_w);
        return (m == MC_WIDE) ? 2 * bank_w : bank_w;
    endfunction

    // In-bank index width.
    function automatic int mc_bank_aw(mc_mode_e m, int addr_w);
        return (m == MC_SPLIT) ? addr_w - 2 : addr_w - 1;
    endfunction

endpackage

// File: rtl/mc_bank.sv
// One sub-bank: a synchronous register array with its own chip and output enable.
// Writes are synchronous when ce and we are high. The read path is combinational
// and drives zero unless both ce and oe are high. Assumes the caller already
// folded ce into we.
module mc_bank #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 2,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              oe,
    input  logic              we,
    input  logic [IDX_W-1:0]  index,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Clear on reset, otherwise store the write word at the indexed cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[index] <= wdata;
        end
    end

    // Gate the stored word onto the bank output only when selected and enabled.
    always_comb begin
        q = (ce && oe) ? cells[index] : '0;
    end

endmodule

// File: rtl/mc_decode.sv
// Address splitter: turns the CPU address and chip select into per-bank chip
// enables and an in-bank index, as chosen by MODE. Bits not used for bank
// selection keep their original order in the index. Assumes ADDR_W >= 3.
module mc_decode
    import mc_pkg::*;
#(
    parameter mc_mode_e MODE = MC_HIGH,
    parameter int ADDR_W     = 4,
    localparam int NB        = mc_banks(MODE),
    localparam int IDX_W     = mc_bank_aw(MODE, ADDR_W)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    output logic [NB-1:0]     bank_ce,
    output logic [IDX_W-1:0]  index
);

    generate
        if (MODE == MC_HIGH) begin : g_high
            assign index = addr[ADDR_W-2:0];
            for (genvar b = 0; b < NB; b++) begin : g_ce
                // Top bit picks the bank.
                assign bank_ce[b] = cs && (addr[ADDR_W-1] == 1'(b));
            end
        end else if (MODE == MC_LOW) begin : g_low
            assign index = addr[ADDR_W-1:1];
            for (genvar b = 0; b < NB; b++) begin : g_ce
                // Bottom bit picks the bank.
                assign bank_ce[b] = cs && (addr[0] == 1'(b));
            end
        end else if (MODE == MC_SPLIT) begin : g_split
            logic [1:0] sel;
            assign sel   = {addr[ADDR_W-1], addr[0]};
            assign index = addr[ADDR_W-2:1];
            for (genvar b = 0; b < NB; b++) begin : g_ce
                // Top and bottom bits together pick one of four banks.
                assign bank_ce[b] = cs && (sel == 2'(b));
            end
        end else begin : g_wide
            assign index = addr[ADDR_W-2:0];
            for (genvar b = 0; b < NB; b++) begin : g_ce
                // All banks share the lower half of the address space.
                assign bank_ce[b] = cs && !addr[ADDR_W-1];
            end
        end
    endgenerate

endmodule

// File: rtl/mc_rdmux.sv
// Read combiner: merges the gated bank outputs into one CPU word.
// Interleaved modes OR the outputs, relying on disabled banks driving zero.
// Width mode concatenates them with bank 0 in the low bits.
module mc_rdmux
    import mc_pkg::*;
#(
    parameter mc_mode_e MODE = MC_HIGH,
    parameter int BANK_W     = 2,
    localparam int NB        = mc_banks(MODE),
    localparam int WORD_W    = mc_word_w(MODE, BANK_W)
) (
    input  logic [NB-1:0][BANK_W-1:0] bank_q,
    output logic [WORD_W-1:0]         word
);

    generate
        if (MODE == MC_WIDE) begin : g_cat
            assign word = bank_q;
        end else begin : g_or
            // OR-reduce the bank outputs; at most one is non-zero.
            always_comb begin
                word = '0;
                for (int b = 0; b < NB; b++) begin
                    word = word | bank_q[b];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mem_composer.sv
// Memory composer top: builds one CPU-visible memory from identical sub-banks.
// MODE picks top-bit, bottom-bit, split or width composition. Read data is
// registered (one cycle). A read during a write is dropped and rdata holds.
// Assumes a single synchronous clock domain and ADDR_W >= 3.
module mem_composer
    import mc_pkg::*;
#(
    parameter mc_mode_e MODE = MC_HIGH,
    parameter int ADDR_W     = 4,
    parameter int BANK_W     = 2,
    localparam int WORD_W    = mc_word_w(MODE, BANK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int NB    = mc_banks(MODE);
    localparam int IDX_W = mc_bank_aw(MODE, ADDR_W);

    logic [NB-1:0]             bank_ce;
    logic [IDX_W-1:0]          index;
    logic [NB-1:0][BANK_W-1:0] bank_q;
    logic [WORD_W-1:0]         word;
    logic                      rd_go;

    mc_decode #(.MODE(MODE), .ADDR_W(ADDR_W)) u_decode (
        .addr    (addr),
        .cs      (cs),
        .bank_ce (bank_ce),
        .index   (index)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            localparam int LO = (MODE == MC_WIDE) ? b * BANK_W : 0;
            mc_bank #(.IDX_W(IDX_W), .DATA_W(BANK_W)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .ce    (bank_ce[b]),
                .oe    (rd),
                .we    (bank_ce[b] && wr),
                .index (index),
                .wdata (wdata[LO +: BANK_W]),
                .q     (bank_q[b])
            );
        end
    endgenerate

    mc_rdmux #(.MODE(MODE), .BANK_W(BANK_W)) u_rdmux (
        .bank_q (bank_q),
        .word   (word)
    );

    assign rd_go = cs && rd && !wr;

    // Capture the combined word on a clean read cycle; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_go) begin
            rdata <= word;
        end
    end

endmodule

// File: rtl/mc_checker.sv
// Property checker for the memory composer, attached to every instance by bind.
// Watches the bus strobes, the internal bank enables and the registered read data.
module mc_checker
    import mc_pkg::*;
#(
    parameter mc_mode_e MODE = MC_HIGH,
    parameter int ADDR_W     = 4,
    parameter int NB         = 2,
    parameter int WORD_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [NB-1:0]     bank_ce,
    input logic [WORD_W-1:0] rdata
);

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> rdata == '0);

    p_read_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd && !wr) |=> $stable(rdata));

    p_collide_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && wr) |=> $stable(rdata));

    p_no_cs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> bank_ce == '0);

    generate
        if (MODE == MC_HIGH) begin : g_high
            p_top_bit_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
                cs |-> bank_ce[addr[ADDR_W-1]] && $onehot(bank_ce));
        end else if (MODE == MC_LOW) begin : g_low
            p_low_bit_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
                cs |-> bank_ce[addr[0]] && $onehot(bank_ce));
        end else if (MODE == MC_SPLIT) begin : g_split
            p_split_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
                cs |-> bank_ce[{addr[ADDR_W-1], addr[0]}] && $onehot(bank_ce));
        end else begin : g_wide
            p_wide_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (cs && !addr[ADDR_W-1]) |-> &bank_ce);
            p_wide_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
                addr[ADDR_W-1] |-> bank_ce == '0);
        end
        if (MODE != MC_WIDE) begin : g_one
            p_single_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bank_ce));
        end
    endgenerate

endmodule

bind mem_composer mc_checker #(
    .MODE   (MODE),
    .ADDR_W (ADDR_W),
    .NB     (NB),
    .WORD_W (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .bank_ce (bank_ce),
    .rdata   (rdata)
);

// File: tb/mem_composer_tb.sv
// Bench: drives one bus into four composer instances (one per mode) and checks
// every read against a bench-side model of the 16 words.
module mem_composer_tb;
    import mc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] wd2 = '0;
    logic [3:0] wd4 = '0;
    logic [1:0] q_hi, q_lo, q_sp;
    logic [3:0] q_wd;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [1:0] m2 [16];
    logic [3:0] m4 [8];

    always #4 clk = ~clk;

    mem_composer #(.MODE(MC_HIGH)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rd(rd), .wr(wr),
        .wdata(wd2), .rdata(q_hi));
    mem_composer #(.MODE(MC_LOW)) u_low (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rd(rd), .wr(wr),
        .wdata(wd2), .rdata(q_lo));
    mem_composer #(.MODE(MC_SPLIT)) u_split (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rd(rd), .wr(wr),
        .wdata(wd2), .rdata(q_sp));
    mem_composer #(.MODE(MC_WIDE)) u_wide (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs(cs), .rd(rd), .wr(wr),
        .wdata(wd4), .rdata(q_wd));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input logic [3:0] a, input logic c, input logic r, input logic w,
                       input logic [1:0] d2, input logic [3:0] d4);
        @(negedge clk);
        addr = a; cs = c; rd = r; wr = w; wd2 = d2; wd4 = d4;
        @(posedge clk);
        #1;
        if (c && w && rst_n) begin
            m2[a] = d2;
            if (a < 8) m4[a[2:0]] = d4;
        end
    endtask

    // Compare all four outputs with the current expected read words.
    task automatic cmp_all(input string tag, input logic [1:0] e2, input logic [3:0] e4);
        chk({tag, " R1 top-bit"}, {2'b00, q_hi}, {2'b00, e2});
        chk({tag, " R2 low-bit"}, {2'b00, q_lo}, {2'b00, e2});
        chk({tag, " R3 split"},   {2'b00, q_sp}, {2'b00, e2});
        chk({tag, " R4 wide"},    q_wd, e4);
    endtask

    // R5: read cycle, result checked one edge later.
    task automatic rd_chk(input string tag, input logic [3:0] a);
        cyc(a, 1'b1, 1'b1, 1'b0, 2'b00, 4'h0);
        cmp_all(tag, m2[a], (a < 8) ? m4[a[2:0]] : 4'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] h2;
        logic [3:0] h4;
        for (int i = 0; i < 16; i++) m2[i] = '0;
        for (int i = 0; i < 8; i++) m4[i] = '0;

        // R9: reset state, with strobes active to show reset dominates.
        rst_n = 1'b0;
        cyc(4'd3, 1'b1, 1'b0, 1'b1, 2'b11, 4'hF);
        cyc(4'd3, 1'b1, 1'b1, 1'b0, 2'b11, 4'hF);
        cmp_all("R9 rdata in reset", 2'b00, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd_chk("R9 cleared word", 4'(a));

        // R5 plus R1..R4: full write/read sweeps with distinct patterns.
        for (int p = 0; p < 3; p++) begin
            for (int a = 0; a < 16; a++)
                cyc(4'(a), 1'b1, 1'b0, 1'b1, 2'((a + p + (a >> 2)) & 3),
                    4'((a * 5 + p * 3 + 7) & 15));
            for (int a = 0; a < 16; a++) rd_chk("R5 sweep", 4'(a));
        end

        // R10: change one word at a time, all others must stay put.
        for (int t = 0; t < 16; t++) begin
            cyc(4'(t), 1'b1, 1'b0, 1'b1, ~m2[t], (t < 8) ? ~m4[t[2:0]] : 4'h9);
            for (int a = 0; a < 16; a++) rd_chk("R10 isolate", 4'(a));
        end

        // R6: idle cycles and changing address without a read keep rdata.
        rd_chk("R6 setup", 4'd2);
        h2 = m2[2]; h4 = m4[2];
        cyc(4'd9, 1'b1, 1'b0, 1'b0, 2'b00, 4'h0);
        cyc(4'd5, 1'b0, 1'b0, 1'b0, 2'b00, 4'h0);
        cmp_all("R6 hold", h2, h4);

        // R7: strobes with cs low neither write nor read.
        cyc(4'd5, 1'b0, 1'b1, 1'b1, ~m2[5], ~m4[5]);
        cmp_all("R7 cs low rdata", h2, h4);
        cyc(4'd5, 1'b0, 1'b1, 1'b0, 2'b00, 4'h0);
        cmp_all("R7 cs low read", h2, h4);
        rd_chk("R7 no write", 4'd5);

        // R8: read and write together; write lands, rdata holds.
        rd_chk("R8 setup", 4'd1);
        h2 = m2[1]; h4 = m4[1];
        cyc(4'd6, 1'b1, 1'b1, 1'b1, ~m2[6], ~m4[6]);
        cmp_all("R8 collision hold", h2, h4);
        rd_chk("R8 collision write", 4'd6);

        // R4: writes above the width-mode range leave the low half unchanged.
        cyc(4'd12, 1'b1, 1'b0, 1'b1, 2'b01, 4'h5);
        rd_chk("R4 outside read", 4'd12);
        rd_chk("R4 no alias", 4'd4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule